// File: doc/BRIEF.md
# Nibble-Wide Register Access Arbiter

This block gives a host access to a bank of eight 8-bit registers through a 4-bit address bus and a 4-bit data bus. The same data pins also carry values out to external display latches. An internal display scanner walks through every register nibble in turn. For each one it runs an update cycle of fixed length, drives that nibble, and pulses a latch strobe on the last clock of the cycle.

A host raises the read strobe or the write strobe to request the bus. The block lets a display cycle that is already running finish. It then grants the bus by raising the enable for the external bus buffer, and it starts no new display cycle until the host lets go. During a granted write, the block turns off its own data drivers and points the external transceiver toward itself. It captures the write on the falling edge of the strobe. During a granted read, it drives the addressed nibble toward the host. When the strobe drops, the grant ends on the next clock and scanning resumes.

Top module: `nibble_reg_arbiter`

## Requirements
- R1: Address bit 3 picks the nibble of a register: 1 selects bits 7:4 and 0 selects bits 3:0. Address bits 2:0 pick one of the eight registers.
- R2: A write takes effect on the first clock edge at which `wr_i` is seen low after being high while the bus was granted. It stores the address and data that were present during the granted write. Only the addressed nibble changes, and the other nibble of that register keeps its value.
- R3: Outside a display cycle, `data_oe_o` is high only while `buf_en_o` and `rd_i` are both high. At that time `data_o` equals the nibble selected by `addr_i`.
- R4: `buf_en_o` is never high during a display cycle. After a strobe is raised, it rises within CYC_LEN+1 clocks.
- R5: During a granted write (`buf_en_o` and `wr_i` both high), `data_oe_o` stays low.
- R6: `dir_o` is 0 during a granted write and 1 at all other times (1 means block toward host).
- R7: `buf_en_o` is low one clock after the host strobe is deasserted.
- R8: With no host request, display cycles repeat. Each holds `disp_act_o` high for exactly CYC_LEN clocks and pulses `disp_strobe_o` on its last clock. During the pulse, `data_oe_o` is high and `data_o` is the nibble at `disp_addr_o`, decoded as in R1. `disp_addr_o` advances by one, modulo 16, from one cycle to the next.
- R9: While reset is asserted, all registers are zero, `buf_en_o` and `data_oe_o` are 0, and `dir_o` is 1.
- R10: While a host request is pending or granted, no new display cycle starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_i | input | 1 | Host read strobe, active high |
| wr_i | input | 1 | Host write strobe, active high |
| addr_i | input | 4 | Host address: bit 3 selects the nibble, bits 2:0 select the register |
| data_i | input | 4 | Host write data |
| data_o | output | 4 | Data driven onto the shared bus |
| data_oe_o | output | 1 | Enable for the block's own data drivers |
| buf_en_o | output | 1 | Enable for the external bus buffer (host grant) |
| dir_o | output | 1 | Transceiver direction: 1 block to host, 0 host to block |
| disp_addr_o | output | 4 | Nibble address of the current display cycle |
| disp_strobe_o | output | 1 | Display latch strobe, last clock of a cycle |
| disp_act_o | output | 1 | Display cycle in progress |

## Verification
The bench drives inputs and samples outputs on falling clock edges. A raised strobe is granted after one to CYC_LEN+1 rising edges, so the bench polls `buf_en_o` and checks that this count stays within the bound. Read data and the direction are checked on the first falling edge with the grant. A write lands on the rising edge after the strobe drops, and `buf_en_o` is checked low on the falling edge that follows. A later read of both nibbles confirms which nibble changed. The display cycle length, the data at the latch strobe and the address step are checked while the bench watches consecutive cycles.

// File: rtl/nra_pkg.sv
package nra_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE  = 2'd0,
    ARB_WAIT  = 2'd1,
    ARB_GRANT = 2'd2
  } arb_state_e;
endpackage

// File: rtl/nra_reg_bank.sv
module nra_reg_bank #(
  parameter int DATA_W = 4,
  parameter int ADDR_W = 4,
  parameter int N_RD   = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [ADDR_W-1:0]             wr_addr_i,
  input  logic [DATA_W-1:0]             wr_data_i,
  input  logic [N_RD-1:0][ADDR_W-1:0]   rd_addr_i,
  output logic [N_RD-1:0][DATA_W-1:0]   rd_data_o
);
  localparam int REG_W  = 2 * DATA_W;
  localparam int N_REGS = 2 ** (ADDR_W - 1);
  localparam int SEL_W  = ADDR_W - 1;

  logic [N_REGS-1:0][REG_W-1:0] regs_q;
  logic [SEL_W-1:0]             wsel;

  assign wsel = wr_addr_i[SEL_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q <= '0;
    end else if (we_i) begin
      if (wr_addr_i[ADDR_W-1]) regs_q[wsel][REG_W-1:DATA_W] <= wr_data_i;
      else                     regs_q[wsel][DATA_W-1:0]     <= wr_data_i;
    end
  end

  for (genvar p = 0; p < N_RD; p++) begin : g_rd
    logic [REG_W-1:0] sel_reg;
    assign sel_reg      = regs_q[rd_addr_i[p][SEL_W-1:0]];
    assign rd_data_o[p] = rd_addr_i[p][ADDR_W-1] ? sel_reg[REG_W-1:DATA_W]
                                                 : sel_reg[DATA_W-1:0];
  end

  // R2
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(regs_q));
endmodule

// File: rtl/nra_disp_scan.sv
module nra_disp_scan #(
  parameter int IDX_W   = 4,
  parameter int CYC_LEN = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  output logic             busy_o,
  output logic             strobe_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam int CNT_W = $clog2(CYC_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CYC_LEN - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
      idx_o  <= '0;
    end else if (busy_o) begin
      if (cnt_q == CNT_LAST) begin
        busy_o <= 1'b0;
        idx_o  <= idx_o + 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (!hold_i) begin
      busy_o <= 1'b1;
      cnt_q  <= '0;
    end
  end

  assign strobe_o = busy_o && (cnt_q == CNT_LAST);

  // R10
  no_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !busy_o) |=> !busy_o);

  // R8
  idx_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> (idx_o == $past(idx_o) + 1'b1) && !busy_o);
endmodule

// File: rtl/nra_arbiter.sv
module nra_arbiter
  import nra_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic disp_busy_i,
  output logic buf_en_o,
  output logic hold_o
);
  arb_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ARB_IDLE:  if (req_i) state_d = disp_busy_i ? ARB_WAIT : ARB_GRANT;
      ARB_WAIT:  if (!req_i) state_d = ARB_IDLE;
                 else if (!disp_busy_i) state_d = ARB_GRANT;
      ARB_GRANT: if (!req_i) state_d = ARB_IDLE;
      default:   state_d = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ARB_IDLE;
    else         state_q <= state_d;
  end

  assign buf_en_o = (state_q == ARB_GRANT);
  assign hold_o   = req_i || (state_q != ARB_IDLE);

  // R4
  grant_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_en_o |-> !disp_busy_i);

  // R7
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_en_o && !req_i) |=> !buf_en_o);
endmodule

// File: rtl/nibble_reg_arbiter.sv
module nibble_reg_arbiter #(
  parameter int DATA_W  = 4,
  parameter int ADDR_W  = 4,
  parameter int CYC_LEN = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              buf_en_o,
  output logic              dir_o,
  output logic [ADDR_W-1:0] disp_addr_o,
  output logic              disp_strobe_o,
  output logic              disp_act_o
);
  localparam int HOST_P = 0;
  localparam int SCAN_P = 1;

  logic                         hold;
  logic                         scan_busy;
  logic                         wr_q;
  logic                         we;
  logic [ADDR_W-1:0]            wa_q;
  logic [DATA_W-1:0]            wd_q;
  logic [1:0][ADDR_W-1:0]       rd_addr;
  logic [1:0][DATA_W-1:0]       rd_data;

  nra_arbiter i_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (rd_i | wr_i),
    .disp_busy_i (scan_busy),
    .buf_en_o    (buf_en_o),
    .hold_o      (hold)
  );

  nra_disp_scan #(.IDX_W(ADDR_W), .CYC_LEN(CYC_LEN)) i_scan (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hold_i   (hold),
    .busy_o   (scan_busy),
    .strobe_o (disp_strobe_o),
    .idx_o    (disp_addr_o)
  );

  // Host write: latch while granted, commit on strobe release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= 1'b0;
      wa_q <= '0;
      wd_q <= '0;
    end else begin
      wr_q <= wr_i && buf_en_o;
      if (wr_i && buf_en_o) begin
        wa_q <= addr_i;
        wd_q <= data_i;
      end
    end
  end

  assign we = buf_en_o && wr_q && !wr_i;

  assign rd_addr[HOST_P] = addr_i;
  assign rd_addr[SCAN_P] = disp_addr_o;

  nra_reg_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_RD(2)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we),
    .wr_addr_i (wa_q),
    .wr_data_i (wd_q),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );

  assign disp_act_o = scan_busy;
  assign data_o     = scan_busy ? rd_data[SCAN_P] : rd_data[HOST_P];
  assign data_oe_o  = scan_busy || (buf_en_o && rd_i && !wr_i);
  assign dir_o      = !(buf_en_o && wr_i);

  // R5
  wr_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_en_o && wr_i) |-> !data_oe_o);

  // R3
  rd_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && !disp_act_o) |-> (buf_en_o && rd_i));

  // R6
  dir_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !buf_en_o |-> dir_o);
endmodule

// File: tb/test_nibble_reg_arbiter.sv
module test_nibble_reg_arbiter;
  localparam int CYC = 4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rd_i = 1'b0, wr_i = 1'b0;
  logic [3:0] addr_i = '0, data_i = '0;
  logic [3:0] data_o, disp_addr_o;
  logic       data_oe_o, buf_en_o, dir_o, disp_strobe_o, disp_act_o;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] mdl [8];

  always #4 clk = ~clk;

  nibble_reg_arbiter #(.CYC_LEN(CYC)) i_nibble_reg_arbiter (
    .clk_i(clk), .rst_ni(rst_ni), .rd_i(rd_i), .wr_i(wr_i),
    .addr_i(addr_i), .data_i(data_i), .data_o(data_o),
    .data_oe_o(data_oe_o), .buf_en_o(buf_en_o), .dir_o(dir_o),
    .disp_addr_o(disp_addr_o), .disp_strobe_o(disp_strobe_o),
    .disp_act_o(disp_act_o)
  );

  function automatic logic [3:0] nib(input logic [3:0] a);
    return a[3] ? mdl[a[2:0]][7:4] : mdl[a[2:0]][3:0];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Full host access; returns data seen during a granted read
  task automatic access(input bit is_wr, input logic [3:0] a,
                        input logic [3:0] d, output logic [3:0] rdata);
    int n = 0;
    rdata = '0;
    @(negedge clk);
    addr_i = a; data_i = d;
    if (is_wr) wr_i = 1'b1; else rd_i = 1'b1;
    do begin
      @(negedge clk);
      n++;
      if (buf_en_o) chk(!disp_act_o, "R4 grant during display", 1, 0);
    end while (!buf_en_o && n < 50);
    chk(n >= 1 && n <= CYC + 1, "R4 grant latency", n, CYC + 1);
    chk(!disp_act_o, "R10 display idle while granted", disp_act_o, 0);
    if (is_wr) begin
      chk(!data_oe_o, "R5 drivers off on write", data_oe_o, 0);
      chk(dir_o == 1'b0, "R6 dir on write", dir_o, 0);
    end else begin
      chk(data_oe_o, "R3 drivers on for read", data_oe_o, 1);
      chk(dir_o == 1'b1, "R6 dir on read", dir_o, 1);
      rdata = data_o;
    end
    @(negedge clk);
    chk(buf_en_o && !disp_act_o, "R10 grant held", buf_en_o, 1);
    rd_i = 1'b0; wr_i = 1'b0;
    @(negedge clk);
    chk(!buf_en_o, "R7 release", buf_en_o, 0);
    chk(dir_o, "R6 dir idle", dir_o, 1);
    if (is_wr) begin
      if (a[3]) mdl[a[2:0]][7:4] = d; else mdl[a[2:0]][3:0] = d;
    end
  endtask

  task automatic host_rd_chk(input logic [3:0] a, input string req);
    logic [3:0] v;
    access(1'b0, a, 4'h0, v);
    chk(v == nib(a), req, v, nib(a));
  endtask

  task automatic scan_watch(input int ncyc);
    int run = 0;
    bit have_prev = 0;
    logic [3:0] prev = '0;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      if (!buf_en_o && !disp_act_o && data_oe_o)
        chk(0, "R3 idle drive", data_oe_o, 0);
      if (disp_act_o) run++;
      else if (run != 0) begin
        chk(run == CYC, "R8 cycle length", run, CYC);
        run = 0;
      end
      if (disp_strobe_o) begin
        chk(data_oe_o && data_o == nib(disp_addr_o), "R8 latch data R1",
            data_o, nib(disp_addr_o));
        if (have_prev)
          chk(disp_addr_o == prev + 4'd1, "R8 address step", disp_addr_o, prev + 4'd1);
        prev = disp_addr_o;
        have_prev = 1;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] dummy;
    for (int r = 0; r < 8; r++) mdl[r] = 8'h00;
    repeat (3) @(negedge clk);
    // R9
    chk(!buf_en_o && !data_oe_o && dir_o, "R9 reset outputs", {buf_en_o, data_oe_o, dir_o}, 1);
    rst_ni = 1'b1;
    scan_watch(5 * 16 * (CYC + 1));
    for (int r = 0; r < 8; r++) begin
      logic [3:0] lo = 4'((r * 7 + 3) & 15);
      logic [3:0] hi = 4'((r * 5 + 10) & 15);
      host_rd_chk(4'(8 + r), "R9 reset value");
      access(1'b1, 4'(r), lo, dummy);
      host_rd_chk(4'(8 + r), "R2 upper untouched");
      host_rd_chk(4'(r), "R1 lower nibble");
      access(1'b1, 4'(8 + r), hi, dummy);
      host_rd_chk(4'(r), "R2 lower untouched");
      host_rd_chk(4'(8 + r), "R1 upper nibble");
    end
    scan_watch(3 * 16 * (CYC + 1));
    for (int a = 0; a < 16; a++) host_rd_chk(4'(a), "R1 sweep");
    for (int a = 15; a >= 0; a--) access(1'b1, 4'(a), 4'(a ^ 9), dummy);
    for (int a = 0; a < 16; a++) host_rd_chk(4'(a), "R2 overwrite");
    scan_watch(2 * 16 * (CYC + 1));
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule